// File: doc/BRIEF.md
# Packed Transfer Curve Lookup

This block applies a piecewise-linear transfer curve to each of three colour channels (R, G, B). Every channel owns a table of `NPTS` points. An input sample's upper bits pick a segment between two neighbouring points. Its lower `FRAC_W` bits then interpolate linearly between those two points. A channel whose enable is clear forwards its sample unchanged. The block is built either as a 33-point curve or as a 41-point curve. The parameter `NPTS` chooses the size, and the size also fixes where the enable bits sit in the control word.

Software loads the tables through two ports. An address port sets the entry pointer. A data port then takes 32-bit words, and each word carries two 16-bit entries. The three tables are stored end to end as one array: R first, then G, then B. Because each table holds an odd number of points, one word carries the last R entry together with the first G entry.

A small state machine guards the tables. In `LD_RUN` the curve is evaluated and the tables are frozen. An address write with an in-range index moves it to `LD_FILL`, where data writes fill the tables and no pixel is accepted. Two transitions return it to `LD_RUN`: a data write that moves the pointer to or past the end of the array, or an address write that is out of range.

Top module: `tcl_curve_lut`

## Requirements
- R1: After reset, `out_valid` is 0 and all outputs are 0. The control enables are all clear. Entry k of every channel table holds k·2^FRAC_W, so with every channel enabled each input below (NPTS−1)·2^FRAC_W comes back unchanged.
- R2: An address write sets the entry pointer to `addr_wdata`. When that value is below 3·NPTS the block enters `LD_FILL`; otherwise it returns to or stays in `LD_RUN`. Writing 0 starts at the first R entry.
- R3: A data write in `LD_FILL` stores bits [15:0] at the pointer and bits [31:16] at pointer+1, then advances the pointer by two. The array index of entry j of channel c (R=0, G=1, B=2) is c·NPTS+j.
- R4: Halves that land at index 3·NPTS or above are dropped. The data write that moves the pointer to 3·NPTS or beyond ends the load. Data writes in `LD_RUN` change no entry.
- R5: In the 33-point build, channel c is enabled when control bit 31 and control bit 27+c are both set (R=27, G=28, B=29).
- R6: In the 41-point build, channel c is enabled when control bit 29+c is set (R=29, G=30, B=31).
- R7: A disabled channel outputs its input sample zero-extended to 16 bits.
- R8: An enabled channel with segment s = in >> FRAC_W below NPTS−1 and fraction f = the low FRAC_W bits outputs e[s] + floor((e[s+1]−e[s])·f / 2^FRAC_W).
- R9: An enabled channel with segment s ≥ NPTS−1 outputs the last entry e[NPTS−1].
- R10: While in `LD_FILL`, `pix_valid` is ignored: `out_valid` is 0 on the next cycle and the outputs hold their values.
- R11: In `LD_RUN`, a sample taken on one rising edge gives `out_valid` = 1 and its result on the outputs after that edge, and `out_valid` = 0 after an edge without `pix_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Address port write strobe |
| addr_wdata | input | PTR_W | Starting entry index |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 32 | Two packed table entries |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word holding the channel enables |
| pix_valid | input | 1 | Input sample valid |
| pix_r | input | IN_W | R input sample |
| pix_g | input | IN_W | G input sample |
| pix_b | input | IN_W | B input sample |
| out_valid | output | 1 | Output sample valid |
| out_r | output | ENT_W | R result |
| out_g | output | ENT_W | G result |
| out_b | output | ENT_W | B result |

## Verification
The assertions are checked on every cycle. They cover the pointer stepping by two per fill write and the pointer staying inside the array while filling. They also cover the tables staying frozen outside a load, the pointer taking the address written, outputs being blocked and held during a load, the one-cycle valid latency, bypass pass-through and top-segment saturation. Some behaviours need the bench's scenarios with a reference model run beside both builds. These are: the straddling R/G word, whole-table contents after a full load, a load restarted from a mid-array index, an out-of-range address cancelling a partial load, the two enable-bit layouts, and interpolation values over rising and falling segments.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
    localparam int NCH = 3;

    typedef enum logic [0:0] {
        LD_RUN  = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;
endpackage

// File: rtl/tcl_loader.sv
module tcl_loader
    import tcl_pkg::*;
#(
    parameter int NPTS   = 33,
    parameter int ENT_W  = 16,
    parameter int FRAC_W = 9,
    parameter int PTR_W  = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            addr_we,
    input  logic [PTR_W-1:0]                addr_wdata,
    input  logic                            data_we,
    input  logic [31:0]                     data_wdata,
    output logic                            busy,
    output logic [NCH*NPTS-1:0][ENT_W-1:0]  tbl
);
    localparam int TOT = NCH * NPTS;

    ld_state_e        state, state_nxt;
    logic [PTR_W-1:0] ptr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_RUN;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            LD_RUN: begin
                if (addr_we && int'(addr_wdata) < TOT) state_nxt = LD_FILL;
            end
            LD_FILL: begin
                if (addr_we)
                    state_nxt = (int'(addr_wdata) < TOT) ? LD_FILL : LD_RUN;
                else if (data_we && int'(ptr) + 2 >= TOT)
                    state_nxt = LD_RUN;
            end
            default: state_nxt = LD_RUN;
        endcase
    end

    assign busy = (state == LD_FILL);

    // pointer and table storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < TOT; i++)
                tbl[i] <= ENT_W'((i % NPTS) << FRAC_W);
        end else if (addr_we) begin
            ptr <= addr_wdata;
        end else if (state == LD_FILL && data_we) begin
            for (int i = 0; i < TOT; i++) begin
                if (i == int'(ptr))
                    tbl[i] <= data_wdata[ENT_W-1:0];
                else if (i == int'(ptr) + 1)
                    tbl[i] <= data_wdata[16 +: ENT_W];
            end
            ptr <= ptr + PTR_W'(2);
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (state == LD_FILL && data_we && !addr_we) |=> ptr == $past(ptr) + PTR_W'(2)); // R3
    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) state == LD_FILL |-> int'(ptr) < TOT); // R4
    AST_TBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) state == LD_RUN |=> $stable(tbl)); // R4
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) addr_we |=> ptr == $past(addr_wdata)); // R2
endmodule

// File: rtl/tcl_ctrl.sv
module tcl_ctrl
    import tcl_pkg::*;
#(
    parameter int NPTS = 33
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctrl_we,
    input  logic [31:0]    ctrl_wdata,
    output logic [NCH-1:0] en
);
    generate
        if (NPTS == 33) begin : g_pts33
            logic           glb_q;
            logic [NCH-1:0] ch_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    glb_q <= 1'b0;
                    ch_q  <= '0;
                end else if (ctrl_we) begin
                    glb_q <= ctrl_wdata[31];
                    ch_q  <= ctrl_wdata[27 +: NCH];
                end
            end
            assign en = ch_q & {NCH{glb_q}};
        end else begin : g_pts41
            logic [NCH-1:0] ch_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       ch_q <= '0;
                else if (ctrl_we) ch_q <= ctrl_wdata[29 +: NCH];
            end
            assign en = ch_q;
        end
    endgenerate
endmodule

// File: rtl/tcl_channel.sv
module tcl_channel #(
    parameter int NPTS   = 33,
    parameter int IN_W   = 14,
    parameter int ENT_W  = 16,
    parameter int FRAC_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take,
    input  logic                        en,
    input  logic [IN_W-1:0]             pix,
    input  logic [NPTS-1:0][ENT_W-1:0]  tbl,
    output logic [ENT_W-1:0]            y
);
    localparam int IDX_W = $clog2(NPTS);
    localparam int PW    = ENT_W + FRAC_W + 3;

    int                    seg;
    logic [FRAC_W-1:0]     frac;
    logic [IDX_W-1:0]      i0, i1;
    logic [ENT_W-1:0]      e0, e1, curve;
    logic signed [PW-1:0]  diff, prod, q, sum;

    always_comb begin
        seg  = int'(pix[IN_W-1:FRAC_W]);
        frac = pix[FRAC_W-1:0];
        if (seg >= NPTS - 1) begin
            i0 = IDX_W'(NPTS - 1);
            i1 = IDX_W'(NPTS - 1);
        end else begin
            i0 = IDX_W'(seg);
            i1 = IDX_W'(seg + 1);
        end
        e0   = tbl[i0];
        e1   = tbl[i1];
        diff = $signed(PW'({1'b0, e1})) - $signed(PW'({1'b0, e0}));
        prod = diff * $signed(PW'({1'b0, frac}));
        q    = prod >>> FRAC_W;
        sum  = $signed(PW'({1'b0, e0})) + q;
        if (sum < 0)
            curve = '0;
        else if (sum > $signed(PW'({1'b0, {ENT_W{1'b1}}})))
            curve = '1;
        else
            curve = sum[ENT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    y <= '0;
        else if (take) y <= en ? curve : ENT_W'(pix);
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n) (take && !en) |=> y == ENT_W'($past(pix))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !take |=> $stable(y)); // R10
    AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n) (take && en && seg >= NPTS - 1) |=> y == $past(tbl[NPTS-1])); // R9
endmodule

// File: rtl/tcl_curve_lut.sv
module tcl_curve_lut
    import tcl_pkg::*;
#(
    parameter int NPTS   = 33,
    parameter int IN_W   = 14,
    parameter int ENT_W  = 16,
    parameter int FRAC_W = 9,
    localparam int TOT   = NCH * NPTS,
    localparam int PTR_W = $clog2(TOT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [PTR_W-1:0]  addr_wdata,
    input  logic              data_we,
    input  logic [31:0]       data_wdata,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              pix_valid,
    input  logic [IN_W-1:0]   pix_r,
    input  logic [IN_W-1:0]   pix_g,
    input  logic [IN_W-1:0]   pix_b,
    output logic              out_valid,
    output logic [ENT_W-1:0]  out_r,
    output logic [ENT_W-1:0]  out_g,
    output logic [ENT_W-1:0]  out_b
);
    logic                           busy;
    logic                           take;
    logic [TOT-1:0][ENT_W-1:0]      tbl;
    logic [NCH-1:0]                 en;
    logic [NCH-1:0][IN_W-1:0]       pix_arr;
    logic [NCH-1:0][ENT_W-1:0]      y_arr;

    assign pix_arr = {pix_b, pix_g, pix_r};
    assign take    = pix_valid && !busy;

    tcl_loader #(
        .NPTS(NPTS), .ENT_W(ENT_W), .FRAC_W(FRAC_W), .PTR_W(PTR_W)
    ) u_loader (
        .clk(clk), .rst_n(rst_n),
        .addr_we(addr_we), .addr_wdata(addr_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .busy(busy), .tbl(tbl)
    );

    tcl_ctrl #(.NPTS(NPTS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .en(en)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            tcl_channel #(
                .NPTS(NPTS), .IN_W(IN_W), .ENT_W(ENT_W), .FRAC_W(FRAC_W)
            ) u_ch (
                .clk(clk), .rst_n(rst_n),
                .take(take), .en(en[c]), .pix(pix_arr[c]),
                .tbl(tbl[c*NPTS +: NPTS]), .y(y_arr[c])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= take;
    end

    assign out_r = y_arr[0];
    assign out_g = y_arr[1];
    assign out_b = y_arr[2];

    AST_LOAD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !out_valid); // R10
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (pix_valid && !busy) |=> out_valid); // R11
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |=> !out_valid); // R11
endmodule

// File: tb/tcl_curve_lut_test.sv
`timescale 1ns/1ps
module tcl_curve_lut_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw = 1'b0;
    logic [6:0]  ad = '0;
    logic        dw = 1'b0;
    logic [31:0] dd = '0;
    logic        cw = 1'b0;
    logic [31:0] cd33 = '0;
    logic [31:0] cd41 = '0;
    logic        pv = 1'b0;
    logic [13:0] pr = '0, pg = '0, pb = '0;

    logic        ov0, ov1;
    logic [15:0] r0, g0, b0, r1, g1, b1;

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    string req = "R1";

    always #2.5 clk = ~clk;

    tcl_curve_lut #(.NPTS(33), .FRAC_W(9)) uut (
        .clk(clk), .rst_n(rst_n), .addr_we(aw), .addr_wdata(ad),
        .data_we(dw), .data_wdata(dd), .ctrl_we(cw), .ctrl_wdata(cd33),
        .pix_valid(pv), .pix_r(pr), .pix_g(pg), .pix_b(pb),
        .out_valid(ov0), .out_r(r0), .out_g(g0), .out_b(b0)
    );

    tcl_curve_lut #(.NPTS(41), .FRAC_W(8)) uut_w (
        .clk(clk), .rst_n(rst_n), .addr_we(aw), .addr_wdata(ad),
        .data_we(dw), .data_wdata(dd), .ctrl_we(cw), .ctrl_wdata(cd41),
        .pix_valid(pv), .pix_r(pr), .pix_g(pg), .pix_b(pb),
        .out_valid(ov1), .out_r(r1), .out_g(g1), .out_b(b1)
    );

    // behavioural reference model, one slot per build
    int          NP[2] = '{33, 41};
    int          FW[2] = '{9, 8};
    int          mt[2][0:122];
    int          mptr[2];
    bit          mload[2];
    logic [31:0] mctrl[2];
    int          mo[2][3];
    bit          mov[2];

    function automatic int px(int c);
        return (c == 0) ? int'(pr) : (c == 1) ? int'(pg) : int'(pb);
    endfunction

    function automatic bit m_en(int k, int c);
        if (k == 0) return mctrl[0][31] && mctrl[0][27+c];
        return mctrl[1][29+c];
    endfunction

    function automatic int m_eval(int k, int c, int x);
        int s, f, e0, e1;
        s = x >> FW[k];
        f = x & ((1 << FW[k]) - 1);
        if (s >= NP[k] - 1) return mt[k][c*NP[k] + NP[k] - 1];
        e0 = mt[k][c*NP[k] + s];
        e1 = mt[k][c*NP[k] + s + 1];
        return e0 + (((e1 - e0) * f) >>> FW[k]);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 3*NP[k]; i++) mt[k][i] = (i % NP[k]) << FW[k];
            mptr[k] = 0; mload[k] = 0; mctrl[k] = '0; mov[k] = 0;
            for (int c = 0; c < 3; c++) mo[k][c] = 0;
        end
    endtask

    task automatic model_edge();
        for (int k = 0; k < 2; k++) begin
            int tot;
            tot = 3 * NP[k];
            if (!mload[k] && pv) begin
                mov[k] = 1;
                for (int c = 0; c < 3; c++)
                    mo[k][c] = m_en(k, c) ? m_eval(k, c, px(c)) : px(c);
            end else begin
                mov[k] = 0;
            end
            if (aw) begin
                mptr[k]  = int'(ad);
                mload[k] = (int'(ad) < tot);
            end else if (dw && mload[k]) begin
                if (mptr[k] < tot)     mt[k][mptr[k]]     = int'(dd[15:0]);
                if (mptr[k] + 1 < tot) mt[k][mptr[k] + 1] = int'(dd[31:16]);
                mptr[k] += 2;
                if (mptr[k] >= tot) mload[k] = 0;
            end
            if (cw) mctrl[k] = (k == 0) ? cd33 : cd41;
        end
    endtask

    task automatic chk(bit ok, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(ov0 == mov[0], "valid33", int'(ov0), int'(mov[0]));
        chk(int'(r0) == mo[0][0], "r33", int'(r0), mo[0][0]);
        chk(int'(g0) == mo[0][1], "g33", int'(g0), mo[0][1]);
        chk(int'(b0) == mo[0][2], "b33", int'(b0), mo[0][2]);
        chk(ov1 == mov[1], "valid41", int'(ov1), int'(mov[1]));
        chk(int'(r1) == mo[1][0], "r41", int'(r1), mo[1][0]);
        chk(int'(g1) == mo[1][1], "g41", int'(g1), mo[1][1]);
        chk(int'(b1) == mo[1][2], "b41", int'(b1), mo[1][2]);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        aw = 0; dw = 0; cw = 0; pv = 0;
    endtask

    task automatic set_px(int x);
        pv = 1;
        pr = 14'(x);
        pg = 14'(x ^ 14'h0a5a);
        pb = 14'(x + 1000);
    endtask

    function automatic int val_a(int i);
        return (i * 7919 + i * i * 13) & 32'hffff;
    endfunction

    function automatic int val_b(int i);
        return (40000 - i * 611 + ((i * i * 97) % 3001)) & 32'hffff;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        req = "R1";
        chk(ov0 == 1'b0, "reset valid33", int'(ov0), 0);
        chk(r0 == 16'h0 && g0 == 16'h0 && b0 == 16'h0, "reset out33", int'(r0), 0);
        chk(ov1 == 1'b0 && r1 == 16'h0, "reset out41", int'(r1), 0);
        rst_n = 1'b1;
        step();

        // R7: bypass after reset, controls clear
        req = "R7";
        for (int i = 0; i < 6; i++) begin
            set_px(i * 2731 + 5);
            step();
            chk(int'(r0) == ((i * 2731 + 5) & 16'h3fff), "bypass direct R7", int'(r0), (i * 2731 + 5) & 16'h3fff);
        end
        // R11: valid drops after idle
        req = "R11";
        step();
        chk(ov0 == 1'b0 && ov1 == 1'b0, "valid low when idle R11", int'(ov0), 0);
        set_px(77); step();
        chk(ov0 == 1'b1, "valid one cycle after sample R11", int'(ov0), 1);

        // R1: identity tables, all channels enabled; R9 saturation in 41-point build
        req = "R1";
        cw = 1; cd33 = 32'hb800_0000; cd41 = 32'he000_0000; step();
        foreach (NP[k]) begin end
        for (int x = 0; x < 16384; x += 1301) begin
            set_px(x); step();
            chk(int'(r0) == x, "identity direct R1", int'(r0), x);
        end
        req = "R9";
        set_px(16383); step();
        chk(int'(r1) == 40 * 256, "saturate direct R9", int'(r1), 40 * 256);
        set_px(40 * 256); step();

        // R2 R3 R10: full load from 0 with pixels offered during fill
        req = "R2";
        aw = 1; ad = 7'd0; step();
        for (int j = 0; j < 62; j++) begin
            req = (j < 50) ? "R10" : "R4";
            dw = 1;
            dd = {16'(val_a(2*j + 1)), 16'(val_a(2*j))};
            if (j % 3 == 0) set_px(j * 251);
            step();
        end
        req = "R4";
        repeat (3) begin
            dw = 1; dd = 32'hdead_beef; step();
        end

        // R8: interpolation sweep with both builds enabled
        req = "R8";
        for (int i = 0; i < 70; i++) begin
            set_px((i * 263 + i * i * 5) & 16'h3fff); step();
        end
        set_px(16383); step();
        set_px(0); step();
        // R3: straddling word, entry 32 of R and entry 0 of G in the 33-point build
        req = "R3";
        set_px(31 * 512 + 300); step();
        set_px(16383); step();

        // R5: 33-point enable layout
        req = "R5";
        cw = 1; cd33 = 32'h3800_0000; cd41 = 32'h4000_0000; step();
        for (int i = 0; i < 5; i++) begin set_px(i * 3001 + 17); step(); end
        cw = 1; cd33 = 32'h9000_0000; step();
        for (int i = 0; i < 5; i++) begin set_px(i * 2999 + 400); step(); end
        // R6: 41-point enable layout
        req = "R6";
        cw = 1; cd41 = 32'ha000_0000; cd33 = 32'ha800_0000; step();
        for (int i = 0; i < 5; i++) begin set_px(i * 3203 + 99); step(); end
        cw = 1; cd33 = 32'hb800_0000; cd41 = 32'he000_0000; step();

        // R2: load starting at index 33 (first G entry of the 33-point build)
        req = "R2";
        aw = 1; ad = 7'd33; step();
        for (int j = 0; j < 45; j++) begin
            req = "R3";
            dw = 1;
            dd = {16'(val_b(2*j + 1)), 16'(val_b(2*j))};
            if (j % 4 == 1) set_px(j * 347);
            step();
        end
        req = "R8";
        for (int i = 0; i < 40; i++) begin set_px((i * 409 + 33) & 16'h3fff); step(); end

        // R4: out-of-range address, data words have no effect
        req = "R4";
        aw = 1; ad = 7'd126; step();
        for (int j = 0; j < 5; j++) begin
            dw = 1; dd = 32'h1234_5678 + j; set_px(j * 1777); step();
        end
        for (int i = 0; i < 10; i++) begin set_px(i * 1601 + 3); step(); end

        // R2 R10: partial load cancelled in one build, moved on in the other
        req = "R10";
        aw = 1; ad = 7'd0; step();
        for (int j = 0; j < 3; j++) begin
            dw = 1; dd = {16'(j * 4000 + 7), 16'(j * 3000 + 9)}; set_px(j * 999); step();
        end
        req = "R2";
        aw = 1; ad = 7'd100; set_px(1234); step();
        for (int j = 0; j < 12; j++) begin
            dw = 1; dd = {16'(val_a(j) ^ 16'h5555), 16'(val_b(j))}; set_px(j * 1311); step();
        end
        req = "R8";
        for (int i = 0; i < 30; i++) begin set_px((i * 547 + 11) & 16'h3fff); step(); end
        req = "R11";
        repeat (3) step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule